// File: doc/BRIEF.md
# Two-Bank Multiplexed-Address DRAM Cycle Controller

This block turns processor bus requests into control sequences for DRAM on two banks. Every bus cycle it runs passes through the states T1, T2, zero or more wait states (TW), T3 and T4. A read or write request supplies a linear word address. The controller shows the row half of that address on a nine-bit multiplexed address output during T1 and the column half from T2 onward. It drives the row strobe, the column strobe and the read or write strobe of the selected bank in a fixed order.

Refresh is requested with a single pulse. The controller keeps such a request pending until it can serve it, and a pending refresh is served before any access. A refresh cycle always has three wait states. It strobes both banks together, asserts the read strobe, and places a free-running refresh row counter on the address pins. The counter advances by one for each refresh.

New work is taken only while the controller is idle or in T4. Taking work in T4 lets cycles run back to back with no idle gap. Inside the block, bit i of the multiplexed address output stands for processor bus address line 2i+1, so the nine bits cover the odd lines A1 to A17. All strobes are active low. The data bus and electrical timing are outside this block.

Top module: `dram_mux_ctl`

## Requirements
- R1: After reset, `ready` is 1, `dram_a` is 0, and all of `ras_n`, `cas_n`, `rd_n` and `wr_n` are high. The refresh row counter starts at 0.
- R2: An accepted request gives exactly the state sequence T1, T2, n wait states, T3, T4 (4+n cycles), starting on the cycle after acceptance. `ready` is 1 only when idle or in T4, and all strobes are high whenever `ready` is 1.
- R3: For an access, `dram_a` equals `acc_addr[17:9]` (row) during T1. It equals `acc_addr[8:0]` (column) from T2 through T4 and does not change while any column strobe is low. When idle, `dram_a` is 0.
- R4: For an access, `ras_n[acc_bank]` is low from T2 through T3. It is high in T1 and T4. The other bank's row strobe stays high.
- R5: `cas_n[acc_bank]` is low from the state right after T2 (the first TW, or T3 when there are no waits) through T3. A column strobe is never low while the row strobe of the same bank is high.
- R6: A read (`acc_write`=0) drives `rd_n` low and a write (`acc_write`=1) drives `wr_n` low, both from T2 through T3. `rd_n` and `wr_n` are never low together.
- R7: The wait count `acc_waits` (0 to 3) is captured when the request is accepted. Changes to it during the cycle have no effect.
- R8: A refresh cycle has exactly 3 wait states. It drives both bits of `ras_n` and of `cas_n` low with the timing of R4 and R5, and drives `rd_n` low. `dram_a` shows the refresh row counter for the whole cycle. The counter is 9 bits wide, goes up by 1 per refresh and wraps from 511 to 0.
- R9: If a refresh is pending or arriving when work can be accepted, the refresh is taken first. A waiting access is then accepted in that refresh's T4.
- R10: `acc_valid` is ignored in T1, TW, T2 and T3 (no `acc_ack`). A `rfsh_req` pulse that arrives during a busy cycle is remembered. Several such pulses merge into one refresh.
- R11: A request present in T4 starts its T1 on the very next cycle, with no idle cycle in between.
- R12: `acc_ack` is high for exactly the cycle in which an access is accepted, and only when `ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Read or write request, held until `acc_ack` |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_bank | input | 1 | Bank select |
| acc_addr | input | 18 | Word address: row in [17:9], column in [8:0] |
| acc_waits | input | 2 | Wait states for this access |
| rfsh_req | input | 1 | Refresh request pulse |
| acc_ack | output | 1 | Access accepted this cycle |
| ready | output | 1 | Idle or in T4; work can be taken |
| dram_a | output | 9 | Multiplexed address; bit i is bus line 2i+1 |
| ras_n | output | 2 | Row strobes, one per bank |
| cas_n | output | 2 | Column strobes, one per bank |
| rd_n | output | 1 | Read strobe |
| wr_n | output | 1 | Write strobe |

## Verification
The bench builds the block with its default parameters: a nine-bit multiplexed address, two banks, a two-bit wait count and three refresh waits. With a nine-bit refresh counter, a wrap from 511 to 0 takes only 512 refreshes, so the bench runs that many and sees the counter roll over. The two-bit wait field lets random traffic cover every cycle length from four to seven states. Directed cases cover a refresh and an access arriving in the same cycle, refresh pulses that arrive mid-cycle and must merge, and wait counts that change while a cycle is in progress.

// File: rtl/dram_mux_pkg.sv
package dram_mux_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_T1,
        ST_T2,
        ST_TW,
        ST_T3,
        ST_T4
    } bus_st_e;

    typedef enum logic [1:0] {
        CK_READ,
        CK_WRITE,
        CK_RFSH
    } cyc_kind_e;

endpackage

// File: rtl/dram_rfsh_ctr.sv
module dram_rfsh_ctr #(
    parameter int MA_W = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step,
    output logic [MA_W-1:0] row
);

    logic [MA_W-1:0] row_d, row_q;

    always_comb begin
        row_d = row_q;
        if (step) begin
            row_d = row_q + MA_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
        end else begin
            row_q <= row_d;
        end
    end

    assign row = row_q;

endmodule

// File: rtl/dram_cyc_seq.sv
module dram_cyc_seq
    import dram_mux_pkg::*;
#(
    parameter int MA_W       = 9,
    parameter int BANK_W     = 1,
    parameter int WAIT_W     = 2,
    parameter int RFSH_WAITS = 3,
    localparam int ADDR_W    = 2 * MA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [BANK_W-1:0] acc_bank,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [WAIT_W-1:0] acc_waits,
    input  logic              rfsh_req,
    input  logic [MA_W-1:0]   rfsh_row,
    output bus_st_e           st,
    output cyc_kind_e         kind,
    output logic [BANK_W-1:0] bank,
    output logic [MA_W-1:0]   row,
    output logic [MA_W-1:0]   col,
    output logic              rfsh_step,
    output logic              acc_ack,
    output logic              ready
);

    localparam int RF_W   = $clog2(RFSH_WAITS + 1);
    localparam int WCNT_W = (WAIT_W > RF_W) ? WAIT_W : RF_W;

    typedef struct packed {
        bus_st_e           st;
        cyc_kind_e         kind;
        logic [BANK_W-1:0] bank;
        logic [MA_W-1:0]   row;
        logic [MA_W-1:0]   col;
        logic [WCNT_W-1:0] wleft;
        logic              rpend;
    } seq_s;

    seq_s seq_d, seq_q;
    logic rfsh_any, take_rf, take_acc, can_take;

    always_comb begin
        seq_d     = seq_q;
        can_take  = (seq_q.st == ST_IDLE) || (seq_q.st == ST_T4);
        rfsh_any  = seq_q.rpend || rfsh_req;
        take_rf   = can_take && rfsh_any;
        take_acc  = can_take && !rfsh_any && acc_valid;

        // Refresh requests are held until served; repeats merge.
        seq_d.rpend = rfsh_any && !take_rf;

        unique case (seq_q.st)
            ST_IDLE: seq_d.st = ST_IDLE;
            ST_T1:   seq_d.st = ST_T2;
            ST_T2:   seq_d.st = (seq_q.wleft == '0) ? ST_T3 : ST_TW;
            ST_TW: begin
                seq_d.wleft = seq_q.wleft - WCNT_W'(1);
                seq_d.st    = (seq_q.wleft == WCNT_W'(1)) ? ST_T3 : ST_TW;
            end
            ST_T3:   seq_d.st = ST_T4;
            ST_T4:   seq_d.st = ST_IDLE;
            default: seq_d.st = ST_IDLE;
        endcase

        if (take_rf) begin
            seq_d.st    = ST_T1;
            seq_d.kind  = CK_RFSH;
            seq_d.row   = rfsh_row;
            seq_d.col   = rfsh_row;
            seq_d.wleft = WCNT_W'(RFSH_WAITS);
        end else if (take_acc) begin
            seq_d.st    = ST_T1;
            seq_d.kind  = acc_write ? CK_WRITE : CK_READ;
            seq_d.bank  = acc_bank;
            seq_d.row   = acc_addr[ADDR_W-1:MA_W];
            seq_d.col   = acc_addr[MA_W-1:0];
            seq_d.wleft = WCNT_W'(acc_waits);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.st    <= ST_IDLE;
            seq_q.kind  <= CK_READ;
            seq_q.bank  <= '0;
            seq_q.row   <= '0;
            seq_q.col   <= '0;
            seq_q.wleft <= '0;
            seq_q.rpend <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign st        = seq_q.st;
    assign kind      = seq_q.kind;
    assign bank      = seq_q.bank;
    assign row       = seq_q.row;
    assign col       = seq_q.col;
    assign rfsh_step = take_rf;
    assign acc_ack   = take_acc;
    assign ready     = can_take;

endmodule

// File: rtl/dram_pin_drv.sv
module dram_pin_drv
    import dram_mux_pkg::*;
#(
    parameter int MA_W   = 9,
    parameter int BANKS  = 2,
    parameter int BANK_W = 1
) (
    input  bus_st_e           st,
    input  cyc_kind_e         kind,
    input  logic [BANK_W-1:0] bank,
    input  logic [MA_W-1:0]   row,
    input  logic [MA_W-1:0]   col,
    output logic [MA_W-1:0]   dram_a,
    output logic [BANKS-1:0]  ras_n,
    output logic [BANKS-1:0]  cas_n,
    output logic              rd_n,
    output logic              wr_n
);

    logic ras_win, cas_win;

    always_comb begin
        ras_win = (st == ST_T2) || (st == ST_TW) || (st == ST_T3);
        cas_win = (st == ST_TW) || (st == ST_T3);
        unique case (st)
            ST_IDLE: dram_a = '0;
            ST_T1:   dram_a = row;
            default: dram_a = col;
        endcase
        rd_n = !(ras_win && (kind != CK_WRITE));
        wr_n = !(ras_win && (kind == CK_WRITE));
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic hit;
        assign hit      = (kind == CK_RFSH) || (bank == BANK_W'(b));
        assign ras_n[b] = !(ras_win && hit);
        assign cas_n[b] = !(cas_win && hit);
    end

endmodule

// File: rtl/dram_mux_ctl.sv
module dram_mux_ctl
    import dram_mux_pkg::*;
#(
    parameter int MA_W       = 9,
    parameter int BANKS      = 2,
    parameter int WAIT_W     = 2,
    parameter int RFSH_WAITS = 3,
    localparam int BANK_W    = (BANKS > 1) ? $clog2(BANKS) : 1,
    localparam int ADDR_W    = 2 * MA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [BANK_W-1:0] acc_bank,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [WAIT_W-1:0] acc_waits,
    input  logic              rfsh_req,
    output logic              acc_ack,
    output logic              ready,
    output logic [MA_W-1:0]   dram_a,
    output logic [BANKS-1:0]  ras_n,
    output logic [BANKS-1:0]  cas_n,
    output logic              rd_n,
    output logic              wr_n
);

    bus_st_e           st;
    cyc_kind_e         kind;
    logic [BANK_W-1:0] cur_bank;
    logic [MA_W-1:0]   cur_row, cur_col, rfsh_row;
    logic              rfsh_step;

    dram_rfsh_ctr #(.MA_W(MA_W)) rfsh_i (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (rfsh_step),
        .row   (rfsh_row)
    );

    dram_cyc_seq #(
        .MA_W       (MA_W),
        .BANK_W     (BANK_W),
        .WAIT_W     (WAIT_W),
        .RFSH_WAITS (RFSH_WAITS)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_bank  (acc_bank),
        .acc_addr  (acc_addr),
        .acc_waits (acc_waits),
        .rfsh_req  (rfsh_req),
        .rfsh_row  (rfsh_row),
        .st        (st),
        .kind      (kind),
        .bank      (cur_bank),
        .row       (cur_row),
        .col       (cur_col),
        .rfsh_step (rfsh_step),
        .acc_ack   (acc_ack),
        .ready     (ready)
    );

    dram_pin_drv #(
        .MA_W   (MA_W),
        .BANKS  (BANKS),
        .BANK_W (BANK_W)
    ) pins_i (
        .st     (st),
        .kind   (kind),
        .bank   (cur_bank),
        .row    (cur_row),
        .col    (cur_col),
        .dram_a (dram_a),
        .ras_n  (ras_n),
        .cas_n  (cas_n),
        .rd_n   (rd_n),
        .wr_n   (wr_n)
    );

endmodule

// File: rtl/dram_mux_ctl_chk.sv
module dram_mux_ctl_chk #(
    parameter int MA_W  = 9,
    parameter int BANKS = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_ack,
    input logic             ready,
    input logic [MA_W-1:0]  dram_a,
    input logic [BANKS-1:0] ras_n,
    input logic [BANKS-1:0] cas_n,
    input logic             rd_n,
    input logic             wr_n
);

    // R5: a column strobe is only low under its own row strobe
    a_r5_cas_under_ras: assert property (@(posedge clk) disable iff (!rst_n)
        ((~cas_n) & ras_n) == '0);

    for (genvar b = 0; b < BANKS; b++) begin : g_ord
        // R5: row strobe already low in the cycle before the column strobe falls
        a_r5_ras_leads_cas: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(cas_n[b]) |-> !$past(ras_n[b]));
    end

    // R6: read and write strobes are exclusive
    a_r6_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R3: column address holds while a column strobe stays low
    a_r3_col_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ((cas_n != '1) && ($past(cas_n) != '1)) |-> $stable(dram_a));

    // R12: acknowledge only when work can be taken
    a_r12_ack_ready: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ack |-> ready);

    // R12: acknowledge is a single-cycle pulse
    a_r12_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ack |=> !acc_ack);

    // R2: strobes all released whenever ready
    a_r2_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (ras_n == '1 && cas_n == '1 && rd_n && wr_n));

endmodule

bind dram_mux_ctl dram_mux_ctl_chk #(.MA_W(MA_W), .BANKS(BANKS)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc_ack (acc_ack),
    .ready   (ready),
    .dram_a  (dram_a),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .rd_n    (rd_n),
    .wr_n    (wr_n)
);

// File: tb/dram_mux_ctl_tb_top.sv
module dram_mux_ctl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        acc_valid, acc_write, acc_bank, rfsh_req;
    logic [17:0] acc_addr;
    logic [1:0]  acc_waits;
    logic        acc_ack, ready, rd_n, wr_n;
    logic [8:0]  dram_a;
    logic [1:0]  ras_n, cas_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;
    logic [8:0] rrow = '0;

    always #10 clk = ~clk;

    dram_mux_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_bank(acc_bank), .acc_addr(acc_addr), .acc_waits(acc_waits),
        .rfsh_req(rfsh_req), .acc_ack(acc_ack), .ready(ready), .dram_a(dram_a),
        .ras_n(ras_n), .cas_n(cas_n), .rd_n(rd_n), .wr_n(wr_n)
    );

    task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", rq, act, exp, $time);
        end
    endtask

    // phase codes: 0 T1, 1 T2, 2 TW, 3 T3, 4 T4; kind: 0 read, 1 write, 2 refresh
    function automatic logic [8:0] e_addr(int ph, int kind, logic [8:0] r, logic [8:0] c);
        if (kind == 2) return r;
        return (ph == 0) ? r : c;
    endfunction

    function automatic logic [1:0] e_strobe(bit on, int kind, bit bk);
        if (!on) return 2'b11;
        if (kind == 2) return 2'b00;
        return bk ? 2'b01 : 2'b10;
    endfunction

    task automatic check_idle(string rq);
        chk({rq, " ready"}, 32'(ready), 1);
        chk({rq, " addr"}, 32'(dram_a), 0);
        chk({rq, " strobes"}, 32'({ras_n, cas_n, rd_n, wr_n}), 32'h3F);
    endtask

    task automatic play(int kind, bit bk, logic [8:0] r, logic [8:0] c, int nw,
                        bit hold, bit tweak, bit pulse_rf);
        string ra, rs, rr;
        ra = (kind == 2) ? "R8" : "R3";
        rs = (kind == 2) ? "R8" : "R4";
        rr = tweak ? "R7" : "R2";
        for (int k = 0; k <= nw + 3; k++) begin
            int ph;
            bit rw, cw;
            if (pulse_rf) rfsh_req = 1'b0;
            #1;
            ph = (k == 0) ? 0 : (k == 1) ? 1 : (k < 2 + nw) ? 2 : (k == 2 + nw) ? 3 : 4;
            rw = (ph >= 1 && ph <= 3);
            cw = (ph == 2 || ph == 3);
            chk(ra, 32'(dram_a), 32'(e_addr(ph, kind, r, c)));
            chk(rs, 32'(ras_n), 32'(e_strobe(rw, kind, bk)));
            chk((kind == 2) ? "R8" : "R5", 32'(cas_n), 32'(e_strobe(cw, kind, bk)));
            chk("R6", 32'({rd_n, wr_n}), 32'({!(rw && kind != 1), !(rw && kind == 1)}));
            chk(rr, 32'(ready), 32'(ph == 4));
            chk((ph == 4) ? "R11" : "R10", 32'(acc_ack), 32'(hold && ph == 4));
            if (k == nw + 3) break;
            if (tweak) acc_waits = 2'($urandom);
            if (pulse_rf && (k == 1 || k == 2)) rfsh_req = 1'b1;
            @(negedge clk);
        end
    endtask

    task automatic do_access(bit wr, bit bk, logic [17:0] ad, logic [1:0] w, bit tweak, bit pulse_rf);
        acc_valid = 1'b1; acc_write = wr; acc_bank = bk; acc_addr = ad; acc_waits = w;
        #1;
        chk("R12", 32'(acc_ack), 1);
        @(negedge clk);
        acc_valid = 1'b0;
        play(wr ? 1 : 0, bk, ad[17:9], ad[8:0], int'(w), 1'b0, tweak, pulse_rf);
    endtask

    task automatic do_refresh();
        rfsh_req = 1'b1;
        #1;
        chk("R9", 32'(acc_ack), 0);
        @(negedge clk);
        rfsh_req = 1'b0;
        play(2, 1'b0, rrow, rrow, 3, 1'b0, 1'b0, 1'b0);
        rrow++;
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            #1;
            check_idle("R2");
        end
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20245));
        rst_n = 1'b0; acc_valid = 0; acc_write = 0; acc_bank = 0; acc_addr = '0;
        acc_waits = '0; rfsh_req = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check_idle("R1");

        // directed read, no waits, bank 0
        do_access(1'b0, 1'b0, 18'h2B5A3, 2'd0, 1'b0, 1'b0);
        idle(2);
        // write, bank 1, 3 waits, wait count disturbed mid-cycle (R7)
        do_access(1'b1, 1'b1, 18'h1C0FF, 2'd3, 1'b1, 1'b0);
        idle(1);
        // first refresh must use row 0 (R1, R8)
        do_refresh();
        idle(1);

        // R9: refresh and access arrive together; access follows back to back (R11)
        acc_valid = 1'b1; acc_write = 1'b0; acc_bank = 1'b1; acc_addr = 18'h3FE01; acc_waits = 2'd1;
        rfsh_req = 1'b1;
        #1;
        chk("R9", 32'(acc_ack), 0);
        @(negedge clk);
        rfsh_req = 1'b0;
        play(2, 1'b0, rrow, rrow, 3, 1'b1, 1'b0, 1'b0);
        rrow++;
        @(negedge clk);
        acc_valid = 1'b0;
        play(0, 1'b1, 9'h1FF, 9'h001, 1, 1'b0, 1'b0, 1'b0);

        // R10: two refresh pulses during a busy cycle give one refresh
        idle(1);
        do_access(1'b1, 1'b0, 18'h05555, 2'd0, 1'b0, 1'b1);
        @(negedge clk);
        play(2, 1'b0, rrow, rrow, 3, 1'b0, 1'b0, 1'b0);
        rrow++;
        idle(2);

        // random traffic with back-to-back starts
        for (int i = 0; i < 120; i++) begin
            int sel;
            sel = int'($urandom % 8);
            if (sel < 3)
                do_access(1'b0, 1'($urandom), 18'($urandom), 2'($urandom), 1'($urandom), 1'b0);
            else if (sel < 6)
                do_access(1'b1, 1'($urandom), 18'($urandom), 2'($urandom), 1'($urandom), 1'b0);
            else if (sel == 6)
                do_refresh();
            else
                idle(1 + int'($urandom % 3));
        end

        // R8: run the refresh row counter through its wrap
        for (int i = 0; i < 520; i++) do_refresh();
        idle(1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule